// File: doc/BRIEF.md
# Small-Value Flagged Byte Store

This block is a byte-wide storage array that can serve as a register file or a small data memory. Each location keeps one extra flag bit that tells whether the stored byte is one of the four small values 0, 1, 2 or 3. Such values fit entirely in the two least significant bits. When one of them is written, only the flag and the two low bits are updated. The upper six stored bits are left as they were.

A read looks at the flag first. For a small value, only the two low bit columns are taken, and the upper six output bits are forced to zero. For any other value, all eight data bits are taken. The array has one write port and one registered read port. Two running counters report how many bit cells each access touched: 3 for a small value (flag plus two bits) and 9 for any other value (flag plus eight bits). This lets the storage activity be measured against the data being handled.

Top module: `cvs_store`

## Requirements
- R1: After reset every location reads as 0x00, and both activity counters read 0.
- R2: Writing a value from 0 to 3 and then reading that location returns exactly the written value.
- R3: An enabled write whose data has its upper six bits all zero (0x00 to 0x03) adds exactly 3 to `wr_bits` in the cycle after the write edge.
- R4: An enabled write of any value from 0x04 to 0xFF stores the full byte, which later reads back unchanged, and adds exactly 9 to `wr_bits`.
- R5: A read of a location that last received a small value returns zero in bits 7:2, even when that location held a large value before. The read adds exactly 3 to `rd_bits`.
- R6: A read of a location that last received a large value adds exactly 9 to `rd_bits`.
- R7: `rd_data` shows the value at `rd_addr` one clock edge after `rd_en` is sampled high, and holds that value while `rd_en` stays low. A read and a write to the same address at the same edge return the value from before the write.
- R8: With `wr_en` low, no location changes and `wr_bits` stays the same. With `rd_en` low, `rd_bits` stays the same.
- R9: The boundary values 0x04 and 0x80 count as large values: each is charged 9 on write and 9 on read, and each reads back exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Write byte |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Registered read byte |
| wr_bits | output | CNT_W | Running total of bit cells written |
| rd_bits | output | CNT_W | Running total of bit cells read |

## Verification
The sharpest corner case is a location that first holds 0xFF and is then overwritten with 2. A design that does not mask the stale upper bits returns 0xFE instead of 0x02. The bench also writes 0x04 and 0x80, which sit just outside the small range. A classifier that tests too few upper bits would charge these 3 cells and lose the upper bits on readback. Reads and writes to the same address at the same edge expose a design that forwards the new data instead of returning the old value. Idle cycles show up any counter that advances without an enabled access.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
   // Number of bit cells an access touches: the flag plus the active data lanes.
   function automatic int unsigned cell_cost(input logic wide, input int unsigned low_w,
                                             input int unsigned data_w);
      return wide ? (1 + data_w) : (1 + low_w);
   endfunction
endpackage

// File: rtl/cvs_classifier.sv
module cvs_classifier #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOW_W  = 2
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              wide_o
);
   localparam int unsigned HI_W = DATA_W - LOW_W;

   // A value is small when every bit above the low lanes is zero.
   assign wide_o = |data_i[DATA_W-1:LOW_W];

   initial begin
      assert (HI_W > 0) else $error("classifier needs upper bits");
   end
endmodule

// File: rtl/cvs_array.sv
module cvs_array #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOW_W  = 2,
   localparam int unsigned ADDR_W = $clog2(DEPTH),
   localparam int unsigned HI_W   = DATA_W - LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_wide,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_flag,
   output logic [LOW_W-1:0]  rd_lo,
   output logic [HI_W-1:0]   rd_hi
);
   logic [DEPTH-1:0]  flag_q;
   logic [LOW_W-1:0]  lo_q [DEPTH];
   logic [HI_W-1:0]   hi_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_addr == ADDR_W'(e));

      // The flag and the low lanes are written on every access to this entry.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[e] <= 1'b0;
            lo_q[e]   <= '0;
         end else if (sel) begin
            flag_q[e] <= wr_wide;
            lo_q[e]   <= wr_data[LOW_W-1:0];
         end
      end

      // The upper lanes are written only for large values. Otherwise they keep stale contents.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             hi_q[e] <= '0;
         else if (sel && wr_wide) hi_q[e] <= wr_data[DATA_W-1:LOW_W];
      end
   end

   assign rd_flag = flag_q[rd_addr];
   assign rd_lo   = lo_q[rd_addr];
   assign rd_hi   = hi_q[rd_addr];

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert ((1 << ADDR_W) == DEPTH) else $error("DEPTH must be a power of two");
   end
endmodule

// File: rtl/cvs_read_probe.sv
module cvs_read_probe #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOW_W  = 2,
   localparam int unsigned HI_W  = DATA_W - LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              flag_i,
   input  logic [LOW_W-1:0]  lo_i,
   input  logic [HI_W-1:0]   hi_i,
   output logic [DATA_W-1:0] data_o
);
   logic [HI_W-1:0] hi_gated;

   // The upper lanes are used only when the flag marks a large value.
   assign hi_gated = flag_i ? hi_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_o <= '0;
      else if (rd_en) data_o <= {hi_gated, lo_i};
   end
endmodule

// File: rtl/cvs_activity_counter.sv
module cvs_activity_counter #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOW_W  = 2,
   parameter int unsigned CNT_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             wide,
   output logic [CNT_W-1:0] count
);
   import cvs_pkg::*;

   logic [CNT_W-1:0] step;
   assign step = CNT_W'(cell_cost(wide, LOW_W, DATA_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (hit) count <= count + step;
   end

   initial begin
      assert (CNT_W >= 8) else $error("counter too narrow");
   end
endmodule

// File: rtl/cvs_store.sv
module cvs_store #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LOW_W  = 2,
   parameter int unsigned CNT_W  = 32,
   localparam int unsigned ADDR_W = $clog2(DEPTH),
   localparam int unsigned HI_W   = DATA_W - LOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  wr_bits,
   output logic [CNT_W-1:0]  rd_bits
);
   localparam logic [CNT_W-1:0] NARROW = CNT_W'(1 + LOW_W);
   localparam logic [CNT_W-1:0] WIDE   = CNT_W'(1 + DATA_W);

   logic             wr_wide;
   logic             rd_flag;
   logic [LOW_W-1:0] rd_lo;
   logic [HI_W-1:0]  rd_hi;

   cvs_classifier #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_class (
      .data_i (wr_data),
      .wide_o (wr_wide)
   );

   cvs_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_wide (wr_wide),
      .rd_addr (rd_addr),
      .rd_flag (rd_flag),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi)
   );

   cvs_read_probe #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_probe (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .flag_i (rd_flag),
      .lo_i   (rd_lo),
      .hi_i   (rd_hi),
      .data_o (rd_data)
   );

   cvs_activity_counter #(.DATA_W(DATA_W), .LOW_W(LOW_W), .CNT_W(CNT_W)) u_wr_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (wr_en),
      .wide  (wr_wide),
      .count (wr_bits)
   );

   cvs_activity_counter #(.DATA_W(DATA_W), .LOW_W(LOW_W), .CNT_W(CNT_W)) u_rd_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (rd_en),
      .wide  (rd_flag),
      .count (rd_bits)
   );

   initial begin
      assert (LOW_W >= 1 && LOW_W < DATA_W) else $error("LOW_W out of range");
   end

   // R3: a small value on the write port costs three cells
   p_wr_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[DATA_W-1:LOW_W] == '0) |=> wr_bits == $past(wr_bits) + NARROW);

   // R4: a large value on the write port costs nine cells
   p_wr_large_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[DATA_W-1:LOW_W] != '0) |=> wr_bits == $past(wr_bits) + WIDE);

   // R8: the write counter does not move without an enabled write
   p_wr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_bits));

   // R8: the read counter does not move without an enabled read
   p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_bits));

   // R5, R6: a narrow read charge goes with zero upper read bits, and a wide charge with nonzero ones
   p_rd_charge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ((rd_bits == $past(rd_bits) + NARROW) == (rd_data[DATA_W-1:LOW_W] == '0)));

   // R7: read data holds while no read is issued
   p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/cvs_store_test.sv
module cvs_store_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [31:0]   wr_bits, rd_bits;

   int total = 0;
   int bad = 0;
   logic [7:0]  model [DEPTH];
   logic [31:0] exp_wr = 0, exp_rd = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cvs_store uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_bits(wr_bits), .rd_bits(rd_bits)
   );

   function automatic int cost(input logic [7:0] v);
      return (v > 8'd3) ? 9 : 3;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      exp_wr += 32'(cost(v));
      model[a] = v;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      exp_rd += 32'(cost(model[a]));
      check(req, {24'd0, rd_data}, {24'd0, model[a]});
      check(req, rd_bits, exp_rd);
   endtask

   task automatic t_reset;
      check("R1", wr_bits, 0);
      check("R1", rd_bits, 0);
      for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R1");
   endtask

   task automatic t_small;
      for (int v = 0; v < 4; v++) begin
         do_write(AW'(v + 1), 8'(v));
         check("R3", wr_bits, exp_wr);
         do_read(AW'(v + 1), "R2");
      end
   endtask

   task automatic t_large;
      do_write(4'd8, 8'hA5);
      check("R4", wr_bits, exp_wr);
      do_read(4'd8, "R6");
      do_write(4'd9, 8'hFF);
      check("R4", wr_bits, exp_wr);
      do_read(4'd9, "R6");
   endtask

   task automatic t_stale;
      do_write(4'd10, 8'hFF);
      do_write(4'd10, 8'h02);
      check("R3", wr_bits, exp_wr);
      do_read(4'd10, "R5");
      do_write(4'd11, 8'hC1);
      do_write(4'd11, 8'h00);
      do_read(4'd11, "R5");
   endtask

   task automatic t_boundary;
      do_write(4'd12, 8'h04);
      check("R9", wr_bits, exp_wr);
      do_read(4'd12, "R9");
      do_write(4'd13, 8'h80);
      check("R9", wr_bits, exp_wr);
      do_read(4'd13, "R9");
   endtask

   task automatic t_idle;
      logic [7:0] held;
      held = rd_data;
      @(negedge clk);
      wr_addr = 4'd8; wr_data = 8'h33; rd_addr = 4'd1;
      repeat (3) @(negedge clk);
      check("R8", wr_bits, exp_wr);
      check("R8", rd_bits, exp_rd);
      check("R7", {24'd0, rd_data}, {24'd0, held});
      do_read(4'd8, "R8");
   endtask

   task automatic t_rdw;
      logic [7:0] old;
      old = model[4'd9];
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd9; wr_data = 8'h01;
      rd_en = 1'b1; rd_addr = 4'd9;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      exp_wr += 32'(cost(8'h01));
      exp_rd += 32'(cost(old));
      model[4'd9] = 8'h01;
      check("R7", {24'd0, rd_data}, {24'd0, old});
      check("R7", rd_bits, exp_rd);
      do_read(4'd9, "R7");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small();
      t_large();
      t_stale();
      t_boundary();
      t_idle();
      t_rdw();
      check("R4", wr_bits, exp_wr);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule